// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a 9-bit first-in first-out buffer. Its write port and read port run on two unrelated free-running clocks, so it can carry a data stream from one clock domain into another. The storage depth is a parameter, and it may be set to 512, 1024, 2048, 4096 or 8192 words. Both ports can work at the same time. The block has fixed empty and full indications and two programmable early-warning indications. All four flags are active-low.

The two threshold values are kept in internal offset registers. They are programmed through the ordinary write data port while a load strobe is held low. The read side has an output enable that floats the read bus. Reads still take place while the bus is floated, so a consumer can discard words without looking at them. An asynchronous active-low reset empties the buffer, restores both thresholds to their default and restarts the load sequence.

Each pointer crosses to the other domain as a Gray code through a chain of synchronizer flops. Each flag is computed and registered in the domain that needs it. The empty and almost-empty flags belong to the read clock. The full and almost-full flags belong to the write clock.

Top module: `fifo9_dualclk`

## Requirements
- R1: After reset, `empty_n` and `almost_empty_n` read 0, `full_n` and `almost_full_n` read 1, and `rd_data` reads 0 while `out_en_n` is low.
- R2: A word is accepted on a rising `wr_clk` edge only when `wr_en1_n`=0, `wr_en2`=1 and `load_n`=1. Words leave in the order they were accepted. A write attempt with either enable inactive stores nothing.
- R3: A word is read on a rising `rd_clk` edge only when both `rd_en1_n` and `rd_en2_n` are 0. The word appears on `rd_data` after that edge. With only one read enable low, nothing is read.
- R4: While `out_en_n`=1, `rd_data` is high impedance. Reads made during that time still remove words from the buffer.
- R5: `empty_n` is 0 whenever the read side sees no stored word. A read attempt while empty is ignored and consumes nothing.
- R6: `full_n` is 0 when DEPTH words are stored. A write attempt while full is ignored and does not disturb stored data.
- R7: `almost_empty_n` is 0 when the stored word count seen by the read side is less than or equal to the almost-empty threshold.
- R8: `almost_full_n` is 0 when the free space seen by the write side is less than or equal to the almost-full threshold.
- R9: While `load_n`=0, each write with `wr_en1_n`=0 and `wr_en2`=1 goes to the threshold registers and not to the buffer, in this fixed cyclic order:
  - almost-empty bits [8:0];
  - almost-empty bits [17:9];
  - almost-full bits [8:0];
  - almost-full bits [17:9];
  - then the order repeats from the start.
- R10: Reset sets both thresholds to 7 and returns the load order to its first slot.
- R11: Each pointer crosses domains as a Gray code that changes by at most one bit per clock. A change on one side reaches the other side's flags within three clocks of that side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_data | input | 9 | Write data, or threshold load data |
| wr_en1_n | input | 1 | Write enable, active low |
| wr_en2 | input | 1 | Write enable, active high |
| load_n | input | 1 | Routes writes to threshold registers when low |
| rd_en1_n | input | 1 | Read enable, active low |
| rd_en2_n | input | 1 | Read enable, active low |
| out_en_n | input | 1 | Read bus drive enable, active low |
| rd_data | output | 9 | Read data, high impedance while out_en_n is high |
| empty_n | output | 1 | Empty flag, active low (read domain) |
| full_n | output | 1 | Full flag, active low (write domain) |
| almost_empty_n | output | 1 | Almost-empty flag, active low (read domain) |
| almost_full_n | output | 1 | Almost-full flag, active low (write domain) |

## Verification
Read data is due on `rd_data` right after the `rd_clk` edge that performs the read. A flag on the same side as the operation changes on that same edge. A flag on the opposite side follows within three edges of its own clock. The bench drives and samples every port on falling edges, so each write result and each own-side flag is read half a cycle after the edge that produced it. After any write that the read side must observe, or any read the write side must observe, the bench waits six cycles before it reads words or checks cross-side flags.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;

   localparam int DATA_W = 9;
   localparam int OFS_W  = 2 * DATA_W;
   localparam int N_OFS_SLOTS = 4;

   typedef logic [DATA_W-1:0] word_t;
   typedef logic [OFS_W-1:0]  ofs_t;

   // Legal depths are the powers of two from 512 to 8192.
   function automatic bit depth_ok(input int d);
      return (d == 512) || (d == 1024) || (d == 2048) ||
             (d == 4096) || (d == 8192);
   endfunction

endpackage

// File: rtl/fifo9_sync.sv
module fifo9_sync #(
   parameter int W      = 10,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/fifo9_mem.sv
module fifo9_mem
   import fifo9_pkg::*;
#(
   parameter int DEPTH = 512,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          wr_clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  word_t         wdata,
   input  logic          rd_clk,
   input  logic          rst_n,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output word_t         rdata
);

   word_t store [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (we) store[waddr] <= wdata;
   end

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= store[raddr];
   end

endmodule

// File: rtl/fifo9_wr_ctrl.sv
module fifo9_wr_ctrl
   import fifo9_pkg::*;
#(
   parameter int DEPTH       = 512,
   parameter int AW          = $clog2(DEPTH),
   parameter int PW          = AW + 1,
   parameter int OFS_DEFAULT = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  word_t         wdata,
   input  logic          en1_n,
   input  logic          en2,
   input  logic          load_n,
   input  logic [PW-1:0] rgray_s,
   output logic          we,
   output logic [AW-1:0] waddr,
   output logic [PW-1:0] wgray,
   output logic          full,
   output logic          afull,
   output ofs_t          ae_ofs
);

   logic          req, ld_fire;
   logic [PW-1:0] wbin, wbin_nx, rbin_s, used_nx, free_nx;
   word_t         ofs_q [N_OFS_SLOTS];
   logic [1:0]    seq;
   ofs_t          af_ofs;

   assign req     = ~en1_n & en2;
   assign ld_fire = req & ~load_n;
   assign we      = req & load_n & ~full;
   assign wbin_nx = wbin + PW'(we);
   assign waddr   = wbin[AW-1:0];

   always_comb begin
      rbin_s[PW-1] = rgray_s[PW-1];
      for (int i = PW - 2; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
   end

   assign used_nx = wbin_nx - rbin_s;
   assign free_nx = PW'(DEPTH) - used_nx;
   assign ae_ofs  = {ofs_q[1], ofs_q[0]};
   assign af_ofs  = {ofs_q[3], ofs_q[2]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
         full  <= 1'b0;
         afull <= 1'b0;
         seq   <= '0;
         for (int k = 0; k < N_OFS_SLOTS; k++)
            ofs_q[k] <= (k % 2 == 0) ? word_t'(OFS_DEFAULT) : '0;
      end else begin
         wbin  <= wbin_nx;
         wgray <= wbin_nx ^ (wbin_nx >> 1);
         full  <= (used_nx == PW'(DEPTH));
         afull <= (ofs_t'(free_nx) <= af_ofs);
         if (ld_fire) begin
            ofs_q[seq] <= wdata;
            seq        <= seq + 2'd1;
         end
      end
   end

   // R6: the write side never sees more than DEPTH words stored
   p_used_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wbin - rbin_s) <= PW'(DEPTH));

   // R6: a write attempt while full leaves the write pointer alone
   p_full_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (full && req && load_n) |=> (wbin == $past(wbin)));

   // R8: a full buffer has no free space, so almost-full must also be set
   p_full_af_r8: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> afull);

   // R9: every load write moves to the next register slot
   p_load_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ld_fire |=> (seq == $past(seq) + 2'd1));

   // R11: the crossing Gray code flips at most one bit per clock
   p_wgray_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wgray ^ $past(wgray)));

endmodule

// File: rtl/fifo9_rd_ctrl.sv
module fifo9_rd_ctrl
   import fifo9_pkg::*;
#(
   parameter int DEPTH = 512,
   parameter int AW    = $clog2(DEPTH),
   parameter int PW    = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en1_n,
   input  logic          en2_n,
   input  logic [PW-1:0] wgray_s,
   input  ofs_t          ae_ofs,
   output logic          re,
   output logic [AW-1:0] raddr,
   output logic [PW-1:0] rgray,
   output logic          empty,
   output logic          aempty
);

   logic          req;
   logic [PW-1:0] rbin, rbin_nx, wbin_s, cnt_nx;

   assign req     = ~en1_n & ~en2_n;
   assign re      = req & ~empty;
   assign rbin_nx = rbin + PW'(re);
   assign raddr   = rbin[AW-1:0];

   always_comb begin
      wbin_s[PW-1] = wgray_s[PW-1];
      for (int i = PW - 2; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
   end

   assign cnt_nx = wbin_s - rbin_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin   <= '0;
         rgray  <= '0;
         empty  <= 1'b1;
         aempty <= 1'b1;
      end else begin
         rbin   <= rbin_nx;
         rgray  <= rbin_nx ^ (rbin_nx >> 1);
         empty  <= (cnt_nx == '0);
         aempty <= (ofs_t'(cnt_nx) <= ae_ofs);
      end
   end

   // R5: the read side never counts more than DEPTH words stored
   p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wbin_s - rbin) <= PW'(DEPTH));

   // R5: a read attempt while empty leaves the read pointer alone
   p_empty_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && req) |=> (rbin == $past(rbin)));

   // R7: zero words is always at or below any threshold
   p_empty_ae_r7: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> aempty);

   // R11: the returning Gray code flips at most one bit per clock
   p_rgray_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rgray ^ $past(rgray)));

endmodule

// File: rtl/fifo9_dualclk.sv
module fifo9_dualclk
   import fifo9_pkg::*;
#(
   parameter int DEPTH       = 512,
   parameter int SYNC_STAGES = 2,
   parameter int OFS_DEFAULT = 7
) (
   input  logic       wr_clk,
   input  logic       rd_clk,
   input  logic       rst_n,
   input  logic [8:0] wr_data,
   input  logic       wr_en1_n,
   input  logic       wr_en2,
   input  logic       load_n,
   input  logic       rd_en1_n,
   input  logic       rd_en2_n,
   input  logic       out_en_n,
   output logic [8:0] rd_data,
   output logic       empty_n,
   output logic       full_n,
   output logic       almost_empty_n,
   output logic       almost_full_n
);

   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   if (!depth_ok(DEPTH)) begin : g_bad_depth
      $error("DEPTH must be 512, 1024, 2048, 4096 or 8192");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (OFS_DEFAULT < 0 || OFS_DEFAULT >= DEPTH) begin : g_bad_ofs
      $error("OFS_DEFAULT must lie inside the depth");
   end

   logic          we, re, full, afull, empty, aempty;
   logic [AW-1:0] waddr, raddr;
   logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
   ofs_t          ae_ofs;
   word_t         rd_q;

   fifo9_wr_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW), .OFS_DEFAULT(OFS_DEFAULT)) u_wr (
      .clk(wr_clk), .rst_n(rst_n), .wdata(wr_data), .en1_n(wr_en1_n),
      .en2(wr_en2), .load_n(load_n), .rgray_s(rgray_s), .we(we),
      .waddr(waddr), .wgray(wgray), .full(full), .afull(afull), .ae_ofs(ae_ofs)
   );

   fifo9_rd_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
      .clk(rd_clk), .rst_n(rst_n), .en1_n(rd_en1_n), .en2_n(rd_en2_n),
      .wgray_s(wgray_s), .ae_ofs(ae_ofs), .re(re), .raddr(raddr),
      .rgray(rgray), .empty(empty), .aempty(aempty)
   );

   fifo9_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
   );

   fifo9_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
   );

   fifo9_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
      .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
      .rd_clk(rd_clk), .rst_n(rst_n), .re(re), .raddr(raddr), .rdata(rd_q)
   );

   assign rd_data        = out_en_n ? {DATA_W{1'bz}} : rd_q;
   assign empty_n        = ~empty;
   assign full_n         = ~full;
   assign almost_empty_n = ~aempty;
   assign almost_full_n  = ~afull;

endmodule

// File: tb/fifo9_dualclk_tb.sv
module fifo9_dualclk_tb;

   localparam int DEPTH = 512;
   localparam int NV    = 10;
   // Vector layout: {op[2:0], data[8:0], expect[8:0]}
   // op: 0 write, 1 write with wr_en2 low, 2 write with wr_en1_n high,
   //     3 read and compare, 4 read with bus floated, 5 settle, 6 read with one enable
   localparam logic [20:0] VEC [NV] = '{
      {3'd0, 9'h101, 9'h000},
      {3'd1, 9'h0AA, 9'h000},
      {3'd0, 9'h055, 9'h000},
      {3'd2, 9'h0BB, 9'h000},
      {3'd0, 9'h1FF, 9'h000},
      {3'd5, 9'h000, 9'h000},
      {3'd6, 9'h000, 9'h000},
      {3'd3, 9'h000, 9'h101},
      {3'd4, 9'h000, 9'h055},
      {3'd3, 9'h000, 9'h1FF}
   };

   logic       wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
   logic [8:0] wr_data = '0;
   logic       wr_en1_n = 1'b1, wr_en2 = 1'b0, load_n = 1'b1;
   logic       rd_en1_n = 1'b1, rd_en2_n = 1'b1, out_en_n = 1'b0;
   wire  [8:0] rd_data;
   wire        empty_n, full_n, almost_empty_n, almost_full_n;

   int total = 0, bad = 0;
   bit done = 1'b0;

   fifo9_dualclk #(.DEPTH(DEPTH)) u_dut (
      .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_data(wr_data),
      .wr_en1_n(wr_en1_n), .wr_en2(wr_en2), .load_n(load_n),
      .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .out_en_n(out_en_n),
      .rd_data(rd_data), .empty_n(empty_n), .full_n(full_n),
      .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n)
   );

   always #4 wr_clk = ~wr_clk;
   initial begin
      #2;
      forever #4 rd_clk = ~rd_clk;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_op(input logic [8:0] d, input logic e1n, input logic e2);
      @(negedge wr_clk);
      wr_data  = d;
      wr_en1_n = e1n;
      wr_en2   = e2;
      @(negedge wr_clk);
      wr_en1_n = 1'b1;
      wr_en2   = 1'b0;
   endtask

   task automatic wr_word(input logic [8:0] d);
      wr_op(d, 1'b0, 1'b1);
   endtask

   task automatic rd_op(input logic both, input logic float_bus, output logic [8:0] d);
      @(negedge rd_clk);
      rd_en1_n = 1'b0;
      rd_en2_n = both ? 1'b0 : 1'b1;
      out_en_n = float_bus;
      @(negedge rd_clk);
      d        = rd_data;
      rd_en1_n = 1'b1;
      rd_en2_n = 1'b1;
      out_en_n = 1'b0;
   endtask

   task automatic settle();
      repeat (6) @(negedge rd_clk);
   endtask

   initial begin
      repeat (200000) @(posedge wr_clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [8:0] d;
      int mism;
      repeat (5) @(negedge wr_clk);
      rst_n = 1'b1;
      repeat (2) @(negedge wr_clk);

      // R1: reset state of flags and read bus
      check(empty_n == 1'b0 && almost_empty_n == 1'b0, "R1 empty flags", {empty_n, almost_empty_n}, 0);
      check(full_n == 1'b1 && almost_full_n == 1'b1, "R1 full flags", {full_n, almost_full_n}, 3);
      check(rd_data === 9'h000, "R1 rd_data", rd_data, 0);

      // R2 R3 R4: table walk
      for (int v = 0; v < NV; v++) begin
         case (VEC[v][20:18])
            3'd0: wr_word(VEC[v][17:9]);
            3'd1: wr_op(VEC[v][17:9], 1'b0, 1'b0);
            3'd2: wr_op(VEC[v][17:9], 1'b1, 1'b1);
            3'd3: begin
               rd_op(1'b1, 1'b0, d);
               check(d === VEC[v][8:0], "R2 order", d, VEC[v][8:0]);
            end
            3'd4: begin
               rd_op(1'b1, 1'b1, d);
               check(d !== VEC[v][8:0], "R4 bus floated", d, 9'h1ff & ~VEC[v][8:0]);
            end
            3'd5: settle();
            default: begin
               rd_op(1'b0, 1'b0, d);
               check(d === VEC[v][8:0], "R3 single enable", d, VEC[v][8:0]);
            end
         endcase
      end
      settle();
      check(empty_n == 1'b0, "R2 blocked writes stored nothing", empty_n, 0);

      // R5: read while empty is ignored
      rd_op(1'b1, 1'b0, d);
      wr_word(9'h033);
      settle();
      rd_op(1'b1, 1'b0, d);
      check(d === 9'h033, "R5 empty read ignored", d, 9'h033);
      settle();

      // R7 R10: default almost-empty threshold of 7
      for (int i = 0; i < 7; i++) wr_word(9'(i));
      settle();
      check(almost_empty_n == 1'b0, "R7 count 7", almost_empty_n, 0);
      wr_word(9'h007);
      settle();
      check(almost_empty_n == 1'b1, "R10 count 8", almost_empty_n, 1);
      rd_op(1'b1, 1'b0, d);
      check(almost_empty_n == 1'b0, "R7 back to 7", almost_empty_n, 0);
      for (int i = 0; i < 7; i++) rd_op(1'b1, 1'b0, d);
      settle();

      // R8 R6: fill to the top
      for (int i = 0; i < DEPTH - 8; i++) wr_word(9'(i));
      check(almost_full_n == 1'b1, "R8 free 8", almost_full_n, 1);
      wr_word(9'(DEPTH - 8));
      check(almost_full_n == 1'b0, "R8 free 7", almost_full_n, 0);
      for (int i = DEPTH - 7; i < DEPTH; i++) wr_word(9'(i));
      check(full_n == 1'b0, "R6 full", full_n, 0);
      wr_word(9'h1EE);
      check(full_n == 1'b0, "R6 still full", full_n, 0);
      settle();
      mism = 0;
      rd_op(1'b1, 1'b0, d);
      if (d !== 9'h000) mism++;
      settle();
      check(full_n == 1'b1, "R11 full clears after read", full_n, 1);
      for (int i = 1; i < DEPTH; i++) begin
         rd_op(1'b1, 1'b0, d);
         if (d !== 9'(i)) mism++;
      end
      check(mism == 0, "R6 stored data intact", mism, 0);
      settle();
      check(empty_n == 1'b0, "R6 write while full dropped", empty_n, 0);

      // R9: load thresholds ae=2, af=3
      load_n = 1'b0;
      wr_word(9'd2); wr_word(9'd0); wr_word(9'd3); wr_word(9'd0);
      load_n = 1'b1;
      settle();
      check(empty_n == 1'b0, "R9 loads not stored", empty_n, 0);
      wr_word(9'h011); wr_word(9'h012);
      settle();
      check(almost_empty_n == 1'b0, "R9 ae at 2", almost_empty_n, 0);
      wr_word(9'h013);
      settle();
      check(almost_empty_n == 1'b1, "R9 ae above 2", almost_empty_n, 1);
      for (int i = 0; i < DEPTH - 7; i++) wr_word(9'(i));
      check(almost_full_n == 1'b1, "R9 free 4", almost_full_n, 1);
      wr_word(9'h0F0);
      check(almost_full_n == 1'b0, "R9 free 3", almost_full_n, 0);

      // R1 R10: reset while holding data
      @(negedge wr_clk);
      rst_n = 1'b0;
      repeat (3) @(negedge wr_clk);
      rst_n = 1'b1;
      repeat (2) @(negedge wr_clk);
      check(empty_n == 1'b0 && almost_empty_n == 1'b0, "R1 reset empties", {empty_n, almost_empty_n}, 0);
      check(full_n == 1'b1 && almost_full_n == 1'b1, "R1 reset clears full", {full_n, almost_full_n}, 3);

      // R9 R10: high part and wrap; sequence restarts at slot 0 after reset
      load_n = 1'b0;
      wr_word(9'd0); wr_word(9'd1); wr_word(9'd7); wr_word(9'd0); wr_word(9'd4);
      load_n = 1'b1;
      for (int i = 0; i < 10; i++) wr_word(9'(i));
      settle();
      check(almost_empty_n == 1'b0, "R9 ae high part and wrap", almost_empty_n, 0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule